// File: doc/BRIEF.md
# Ternary Match Lookup Table

This block is a small ternary match table for forwarding-prefix and classifier-rule lookups. Each slot holds a comparison key, a care mask and an association byte, plus an occupancy bit. A search key is presented together with a strobe. It is compared against every occupied slot in the same cycle. Bits whose mask bit is clear are treated as don't-care.

When more than one slot matches, the slot with the smallest index wins. Longest-prefix match therefore comes from loading longer prefixes into lower slots. The result is registered. One cycle after the strobe, the block reports hit or miss together with the winning slot's association value, or zero on a miss.

A single write port loads one slot per cycle with key, mask, data and occupancy. Writing a slot with occupancy clear removes it from matching.

Top module: `tcam_lookup`

## Requirements
- R1: After reset no slot is occupied, and res_valid, res_hit, res_miss and res_data are all zero. A search on the empty table misses.
- R2: A write with wr_en=1 stores wr_key, wr_mask, wr_data and wr_valid into slot wr_idx. Searches issued in any later cycle see the new contents.
- R3: A search issued in the same cycle as a write to the slot it would match sees the slot's contents from before that write.
- R4: Key bit b is compared only when mask bit b is 1. A mask bit of 0 makes that key bit don't-care.
- R5: When several occupied slots match, the result carries the data of the lowest-numbered matching slot.
- R6: When no occupied slot matches, res_miss=1, res_hit=0 and res_data=0.
- R7: res_valid is 1 exactly one cycle after srch_valid was 1 and 0 otherwise. While res_valid is 0, res_hit, res_miss and res_data are 0. Searches may be issued on consecutive cycles.
- R8: Writing a slot with wr_valid=0 prevents that slot from matching any later search.
- R9: Whenever res_valid is 1, exactly one of res_hit and res_miss is 1.
- R10: A slot whose mask is all zero matches every search key and serves as a default route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one slot |
| wr_idx | input | $clog2(ENTRIES) | Slot number to write |
| wr_key | input | KEY_W | Key to store |
| wr_mask | input | KEY_W | Care mask to store (1 = compare) |
| wr_data | input | DATA_W | Association value to store |
| wr_valid | input | 1 | Occupancy bit to store (0 invalidates) |
| srch_valid | input | 1 | Search strobe |
| srch_key | input | KEY_W | Key to look up |
| res_valid | output | 1 | Result strobe, one cycle after the search |
| res_hit | output | 1 | Some occupied slot matched |
| res_miss | output | 1 | No occupied slot matched |
| res_data | output | DATA_W | Winning slot's association value, 0 on miss |

## Verification
The embedded properties watch several behaviours on every cycle. They check the fixed one-cycle result timing and that hit and miss never coexist. They check that a miss carries zero data and that a written slot holds what was written one cycle later. They also check that the priority grant is a single slot, is drawn from the match vector, and has no lower-numbered match beneath it.

Only the bench scenarios show the rest. These are the ternary don't-care comparisons, longest-prefix ordering across overlapping prefixes, and the catch-all slot. They also cover invalidation and the read-before-write view of a slot written in the same cycle as a search. The bench checks these against its own shadow table.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    localparam int unsigned DEF_ENTRIES = 16;
    localparam int unsigned DEF_KEY_W   = 32;
    localparam int unsigned DEF_DATA_W  = 8;
endpackage

// File: rtl/tcam_slot_bank.sv
module tcam_slot_bank #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned KEY_W   = 32,
    parameter int unsigned DATA_W  = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [KEY_W-1:0]  wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    input  logic [KEY_W-1:0]  srch_key,
    output logic [ENTRIES-1:0] match,
    output logic [DATA_W-1:0] slot_data [ENTRIES]
);
    typedef struct packed {
        logic              occ;
        logic [KEY_W-1:0]  key;
        logic [KEY_W-1:0]  care;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t tbl_d [ENTRIES];
    slot_t tbl_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        if (wr_en) begin
            tbl_d[wr_idx].occ  = wr_valid;
            tbl_d[wr_idx].key  = wr_key;
            tbl_d[wr_idx].care = wr_mask;
            tbl_d[wr_idx].data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g]     = tbl_q[g].occ &&
                              (((srch_key ^ tbl_q[g].key) & tbl_q[g].care) == '0);
        assign slot_data[g] = tbl_q[g].data;
    end

    // R2: the addressed slot holds the written fields one cycle later
    assert_slot_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q[$past(wr_idx)].occ == $past(wr_valid)) &&
                  (tbl_q[$past(wr_idx)].data == $past(wr_data)) &&
                  (tbl_q[$past(wr_idx)].care == $past(wr_mask)));
endmodule

// File: rtl/tcam_prio_pick.sv
module tcam_prio_pick #(
    parameter int unsigned ENTRIES = 16
) (
    input  logic [ENTRIES-1:0] match,
    output logic [ENTRIES-1:0] grant,
    output logic               any
);
    always_comb begin
        grant = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
        any = |match;
    end
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
    import tcam_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned KEY_W   = DEF_KEY_W,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [KEY_W-1:0]  wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    input  logic              srch_valid,
    input  logic [KEY_W-1:0]  srch_key,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic [DATA_W-1:0] res_data
);
    typedef struct packed {
        logic              vld;
        logic              hit;
        logic              miss;
        logic [DATA_W-1:0] data;
    } res_t;

    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] grant;
    logic               any;
    logic [DATA_W-1:0]  slot_data [ENTRIES];
    logic [DATA_W-1:0]  sel_data;
    res_t res_d, res_q;

    tcam_slot_bank #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .DATA_W(DATA_W)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key), .wr_mask(wr_mask),
        .wr_data(wr_data), .wr_valid(wr_valid),
        .srch_key(srch_key), .match(match), .slot_data(slot_data)
    );

    tcam_prio_pick #(.ENTRIES(ENTRIES)) pick_i (
        .match(match), .grant(grant), .any(any)
    );

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel_data = sel_data | (slot_data[i] & {DATA_W{grant[i]}});
        end
        res_d      = '0;
        res_d.vld  = srch_valid;
        res_d.hit  = srch_valid && any;
        res_d.miss = srch_valid && !any;
        res_d.data = (srch_valid && any) ? sel_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.vld;
    assign res_hit   = res_q.hit;
    assign res_miss  = res_q.miss;
    assign res_data  = res_q.data;

    assert_search_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        srch_valid |=> res_valid);
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_valid |=> (!res_valid && !res_hit && !res_miss && res_data == '0));
    assert_hit_miss_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot({res_hit, res_miss}));
    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_data == '0));
    assert_grant_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~match) == '0) && (any == (grant != '0)));
    assert_grant_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (((grant - 1'b1) & match) == '0));
endmodule

// File: tb/tcam_lookup_tb.sv
module tcam_lookup_tb_top;
    localparam int N  = 16;
    localparam int KW = 32;
    localparam int DW = 8;
    localparam int IW = $clog2(N);
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [KW-1:0] wr_key = '0;
    logic [KW-1:0] wr_mask = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_valid = 1'b0;
    logic          srch_valid = 1'b0;
    logic [KW-1:0] srch_key = '0;
    logic          res_valid, res_hit, res_miss;
    logic [DW-1:0] res_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tcam_lookup dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
        .wr_mask(wr_mask), .wr_data(wr_data), .wr_valid(wr_valid),
        .srch_valid(srch_valid), .srch_key(srch_key), .res_valid(res_valid),
        .res_hit(res_hit), .res_miss(res_miss), .res_data(res_data)
    );

    typedef struct {
        logic          hit;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;

    // shadow table
    logic          m_occ  [N];
    logic [KW-1:0] m_key  [N];
    logic [KW-1:0] m_care [N];
    logic [DW-1:0] m_data [N];

    function automatic exp_t predict(logic [KW-1:0] k, string req);
        exp_t e;
        e.hit = 1'b0; e.data = '0; e.req = req;
        for (int i = 0; i < N; i++) begin
            if (!e.hit && m_occ[i] && (((k ^ m_key[i]) & m_care[i]) == '0)) begin
                e.hit = 1'b1;
                e.data = m_data[i];
            end
        end
        return e;
    endfunction

    task automatic step(bit dw, int idx, logic [KW-1:0] k, logic [KW-1:0] m,
                        logic [DW-1:0] d, bit v, bit ds, logic [KW-1:0] sk, string req);
        @(negedge clk);
        wr_en = dw; wr_idx = IW'(idx); wr_key = k; wr_mask = m; wr_data = d; wr_valid = v;
        srch_valid = ds; srch_key = sk;
        if (ds) exp_q.push_back(predict(sk, req));
        if (dw) begin
            m_occ[idx] = v; m_key[idx] = k; m_care[idx] = m; m_data[idx] = d;
        end
    endtask

    task automatic wr(int idx, logic [KW-1:0] k, logic [KW-1:0] m, logic [DW-1:0] d, bit v);
        step(1'b1, idx, k, m, d, v, 1'b0, '0, "");
    endtask

    task automatic srch(logic [KW-1:0] sk, string req);
        step(1'b0, 0, '0, '0, '0, 1'b0, 1'b1, sk, req);
    endtask

    task automatic idle();
        step(1'b0, 0, '0, '0, '0, 1'b0, 1'b0, '0, "");
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (res_valid) begin
                    exp_t e;
                    n_cmp++;
                    if (exp_q.size() == 0) begin
                        n_bad++;
                        $display("FAIL R7: unexpected result, actual valid=1 expected valid=0");
                    end else begin
                        e = exp_q.pop_front();
                        if (res_hit !== e.hit || res_miss !== !e.hit || res_data !== e.data) begin
                            n_bad++;
                            $display("FAIL %s: actual hit=%0b miss=%0b data=%h expected hit=%0b miss=%0b data=%h",
                                     e.req, res_hit, res_miss, res_data, e.hit, !e.hit, e.data);
                        end
                    end
                end else begin
                    n_cmp++;
                    if (exp_q.size() != 0 || res_hit || res_miss || res_data != '0) begin
                        n_bad++;
                        $display("FAIL R7: idle cycle actual hit=%0b miss=%0b data=%h pending=%0d expected all zero, none pending",
                                 res_hit, res_miss, res_data, exp_q.size());
                        exp_q.delete();
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual run still going, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_occ[i] = 1'b0; m_key[i] = '0; m_care[i] = '0; m_data[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (res_valid || res_hit || res_miss || res_data != '0) begin
            n_bad++;
            $display("FAIL R1: reset outputs actual %0b%0b%0b %h expected 000 00",
                     res_valid, res_hit, res_miss, res_data);
        end
        @(negedge clk);
        rst_n = 1'b1;

        srch(32'h0A00_0001, "R1");                          // empty table misses
        // R3: write slot 3 while searching a key it would match
        step(1'b1, 3, 32'h0A00_0000, 32'hFF00_0000, 8'h11, 1'b1, 1'b1, 32'h0A01_0203, "R3");
        srch(32'h0A01_0203, "R2");                          // new contents visible
        srch(32'h0A77_FFFF, "R4");                          // don't-care low bits
        srch(32'h0B00_0000, "R4");                          // cared bit differs -> miss
        wr(1, 32'h0A01_0000, 32'hFFFF_0000, 8'h22, 1'b1);
        srch(32'h0A01_0203, "R5");                          // longer prefix at slot 1 wins
        srch(32'h0A02_0203, "R5");                          // only slot 3 matches
        wr(15, 32'h1234_5678, 32'h0000_0000, 8'h33, 1'b1);
        srch(32'hC0A8_0101, "R10");                         // catch-all
        srch(32'h0A01_9999, "R5");                          // slot 1 over 3 and 15
        wr(1, 32'h0A01_0000, 32'hFFFF_0000, 8'h22, 1'b0);    // invalidate
        srch(32'h0A01_0203, "R8");
        wr(15, 32'h0, 32'h0, 8'h33, 1'b0);
        srch(32'hC0A8_0101, "R6");
        wr(0, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 8'h44, 1'b1);
        srch(32'hDEAD_BEEF, "R4");                          // exact match
        srch(32'hDEAD_BEEE, "R6");                          // one bit off
        // R3: overwrite slot 3 data during a search of it
        step(1'b1, 3, 32'h0A00_0000, 32'hFF00_0000, 8'h55, 1'b1, 1'b1, 32'h0A05_0505, "R3");
        srch(32'h0A05_0505, "R2");
        idle();
        // R7: back-to-back searches
        for (int j = 0; j < 6; j++) begin
            srch((j % 2 == 0) ? 32'hDEAD_BEEF : 32'h0A00_00FF, "R7");
        end
        idle();
        idle();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule